// File: doc/BRIEF.md
# Multiplexed Fluorescent Display Scan Controller

This block runs a multiplexed vacuum fluorescent display from an internal pattern store. It lights one digit (grid) at a time, in ascending order, from digit 0 up to a programmable count of 1 to 16 digits. While a digit is lit, that digit's stored pattern appears on the segment lines. Each digit slot has a fixed layout. It opens with a blanking gap in which every line is low. A short key strobe follows, in which one segment line drives a column of a key matrix. The lit window comes last, and its length is set by a 3-bit brightness level. A frame is one pass over all enabled digits.

The eight key-return inputs are sampled once per slot, so one frame reads one 8-key column for each enabled digit. A column's reported state changes only when two consecutive frames agree. The upper eight grid lines act as grid lines only for digits that are enabled. When a digit is not enabled, its upper line carries an extra segment bit instead. All writes from the register port go to a pending copy, and that copy becomes visible only at a frame boundary, so a frame never shows a mix of old and new data.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every grid line and segment line, `frame_done` and the whole key map read 0. After reset the block shows one digit with brightness level 0 and an all-zero pattern store.
- R2: Each slot lasts 22 clocks. A frame covers the enabled digits 0 to N-1 in order, so it lasts 22·N clocks. `frame_done` is high for exactly the last cycle of each frame, and at most one enabled grid line is high at any time.
- R3: During the first 4 clocks of every slot, all grid and segment outputs are 0.
- R4: During the next 2 clocks of slot d, all grid lines are low, segment line d is high and every other segment line is low.
- R5: In the remaining 16 clocks, for brightness level L, the first 2·(L+1) clocks light the digit: grid line d is high and segment line i shows bit i of pattern word d. All lines are low for the rest of the slot.
- R6: Grid line 8+k (k = 0..7) is a grid line only while the digit count is above 8+k. Otherwise, during the lit window, it shows bit 24+k of the pattern word of the digit being shown, and it is low at all other times.
- R7: On a write, address 0..15 loads the 32-bit pattern word of that digit. Address 16 loads the control word: bits 3:0 hold the digit count minus 1 and bits 6:4 hold the brightness level. Writes to addresses 17..31 change nothing.
- R8: A write takes effect at the first frame boundary after it, so the frame in which it arrives is shown entirely with the old settings.
- R9: `key_ret` is active high. It is sampled in the last strobe clock of slot d, and return line r lands in key-map bit d·8+r.
- R10: At each frame end, column d (for d below the digit count) of the key map takes the new sample only if it equals the sample from the previous frame, and otherwise keeps its value. Columns at or above the digit count, together with their sample history, are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address: 0..15 pattern words, 16 control |
| wr_data | input | 32 | Write data |
| key_ret | input | 8 | Key-matrix return lines, active high |
| grid_o | output | 16 | Grid lines; upper eight may carry segment bits 24..31 |
| seg_o | output | 24 | Dedicated segment lines |
| frame_done | output | 1 | One-cycle pulse in the last cycle of each frame |
| key_map | output | 128 | Debounced key state, bit d·8+r |

## Verification
A slot counter that is off by one, or a digit index that is wrong, makes grid and segment lines move out of place within a single slot. The phase of `frame_done` then drifts in the first frame. A pattern store or control register that is out of step shows up as wrong segment bits or a wrong frame length. It appears in the first lit window of the frame after the write, or inside the write's own frame if the shadowing is broken. Faults in the key sampling or the debounce history show up in the key map at the first or second frame boundary after the key pattern changes.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

   // Position inside a digit slot, in time order.
   typedef enum logic [1:0] {
      PH_BLANK  = 2'd0,
      PH_STROBE = 2'd1,
      PH_LIT    = 2'd2,
      PH_DARK   = 2'd3
   } vfd_phase_e;

   // Width of the brightness field in the control word.
   localparam int DIM_W = 3;

endpackage

// File: rtl/vfd_timing.sv
module vfd_timing
   import vfd_pkg::*;
#(
   parameter int N_GRID      = 16,
   parameter int BLANK_CLKS  = 4,
   parameter int STROBE_CLKS = 2,
   parameter int STEP_CLKS   = 2,
   localparam int DW         = $clog2(N_GRID),
   localparam int SLOT       = BLANK_CLKS + STROBE_CLKS + 8 * STEP_CLKS,
   localparam int CW         = $clog2(SLOT)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    ndig_m1,
   input  logic [DIM_W-1:0] dim,
   output logic [DW-1:0]    digit,
   output vfd_phase_e       phase,
   output logic             frame_end,
   output logic             key_smp
);

   logic [CW-1:0] cnt_q;
   logic [DW-1:0] dig_q;
   logic          slot_last;
   logic [CW:0]   lit_len;
   logic [CW:0]   lit_pos;

   assign slot_last = (cnt_q == CW'(SLOT - 1));
   assign frame_end = slot_last && (dig_q == ndig_m1);
   assign digit     = dig_q;
   assign key_smp   = (cnt_q == CW'(BLANK_CLKS + STROBE_CLKS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dig_q <= '0;
      end else if (slot_last) begin
         cnt_q <= '0;
         dig_q <= frame_end ? '0 : dig_q + 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // Lit window: (level+1) steps counted from the end of the strobe.
   assign lit_len = (CW+1)'(dim) * (CW+1)'(STEP_CLKS) + (CW+1)'(STEP_CLKS);
   assign lit_pos = {1'b0, cnt_q} - (CW+1)'(BLANK_CLKS + STROBE_CLKS);

   always_comb begin
      if (cnt_q < CW'(BLANK_CLKS))
         phase = PH_BLANK;
      else if (cnt_q < CW'(BLANK_CLKS + STROBE_CLKS))
         phase = PH_STROBE;
      else if (lit_pos < lit_len)
         phase = PH_LIT;
      else
         phase = PH_DARK;
   end

   if (BLANK_CLKS < 1) begin : g_bad_blank
      $error("vfd_timing: BLANK_CLKS must be at least 1");
   end
   if (STROBE_CLKS < 2) begin : g_bad_strobe
      $error("vfd_timing: STROBE_CLKS must be at least 2 so returns settle");
   end
   if (STEP_CLKS < 1) begin : g_bad_step
      $error("vfd_timing: STEP_CLKS must be at least 1");
   end

endmodule

// File: rtl/vfd_shadow.sv
module vfd_shadow
   import vfd_pkg::*;
#(
   parameter int N_GRID = 16,
   parameter int SEG_W  = 32,
   localparam int DW    = $clog2(N_GRID),
   localparam int AW    = DW + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [SEG_W-1:0] wr_data,
   input  logic             frame_end,
   input  logic [DW-1:0]    digit,
   output logic [SEG_W-1:0] row_o,
   output logic [DW-1:0]    ndig_m1_o,
   output logic [DIM_W-1:0] dim_o
);

   localparam logic [AW-1:0] CTRL_ADDR = AW'(N_GRID);

   logic [SEG_W-1:0] pend_q [N_GRID];
   logic [SEG_W-1:0] act_q  [N_GRID];
   logic [DW-1:0]    pend_ndig_q, act_ndig_q;
   logic [DIM_W-1:0] pend_dim_q,  act_dim_q;
   logic             ctrl_hit;

   assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < N_GRID; r++) pend_q[r] <= '0;
      end else if (wr_en && !wr_addr[AW-1]) begin
         pend_q[wr_addr[DW-1:0]] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_ndig_q <= '0;
         pend_dim_q  <= '0;
      end else if (ctrl_hit) begin
         pend_ndig_q <= wr_data[DW-1:0];
         pend_dim_q  <= wr_data[DW +: DIM_W];
      end
   end

   // Whole pending copy moves to the live copy in one edge at frame end.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < N_GRID; r++) act_q[r] <= '0;
         act_ndig_q <= '0;
         act_dim_q  <= '0;
      end else if (frame_end) begin
         for (int r = 0; r < N_GRID; r++) act_q[r] <= pend_q[r];
         act_ndig_q <= pend_ndig_q;
         act_dim_q  <= pend_dim_q;
      end
   end

   assign row_o     = act_q[digit];
   assign ndig_m1_o = act_ndig_q;
   assign dim_o     = act_dim_q;

   if (SEG_W < DW + DIM_W) begin : g_bad_word
      $error("vfd_shadow: data word too narrow for control fields");
   end

endmodule

// File: rtl/vfd_keyscan.sv
module vfd_keyscan #(
   parameter int N_COL = 16,
   parameter int N_RET = 8,
   localparam int DW   = $clog2(N_COL)
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_RET-1:0]       key_ret,
   input  logic                   key_smp,
   input  logic                   frame_end,
   input  logic [DW-1:0]          digit,
   input  logic [DW-1:0]          ndig_m1,
   output logic [N_COL*N_RET-1:0] key_map
);

   logic [N_COL-1:0][N_RET-1:0] cur_q;
   logic [N_COL-1:0][N_RET-1:0] prev_q;
   logic [N_COL-1:0][N_RET-1:0] map_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         prev_q <= '0;
         map_q  <= '0;
      end else begin
         for (int c = 0; c < N_COL; c++) begin
            if (key_smp && (digit == DW'(c))) begin
               cur_q[c] <= key_ret;
            end else if (frame_end) begin
               if (DW'(c) > ndig_m1) begin
                  cur_q[c]  <= '0;
                  prev_q[c] <= '0;
                  map_q[c]  <= '0;
               end else begin
                  if (cur_q[c] == prev_q[c]) map_q[c] <= cur_q[c];
                  prev_q[c] <= cur_q[c];
               end
            end
         end
      end
   end

   assign key_map = map_q;

endmodule

// File: rtl/vfd_drive.sv
module vfd_drive
   import vfd_pkg::*;
#(
   parameter int N_GRID    = 16,
   parameter int N_SEG_DED = 24,
   parameter int N_SHARED  = 8,
   localparam int DW       = $clog2(N_GRID),
   localparam int SEG_W    = N_SEG_DED + N_SHARED,
   localparam int FIRST_SH = N_GRID - N_SHARED
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  vfd_phase_e           phase,
   input  logic [DW-1:0]        digit,
   input  logic [DW-1:0]        ndig_m1,
   input  logic [SEG_W-1:0]     row,
   output logic [N_GRID-1:0]    grid_o,
   output logic [N_SEG_DED-1:0] seg_o
);

   logic                 lit;
   logic                 strobe;
   logic [N_GRID-1:0]    grid_n;
   logic [N_SEG_DED-1:0] seg_n;

   assign lit    = (phase == PH_LIT);
   assign strobe = (phase == PH_STROBE);

   for (genvar j = 0; j < N_GRID; j++) begin : g_grid
      if (j < FIRST_SH) begin : g_fixed
         assign grid_n[j] = lit && (digit == DW'(j));
      end else begin : g_shared
         // Grid while the digit is enabled, otherwise an extra segment bit.
         assign grid_n[j] = (ndig_m1 >= DW'(j)) ? (lit && (digit == DW'(j)))
                                                 : (lit && row[N_SEG_DED + j - FIRST_SH]);
      end
   end

   for (genvar i = 0; i < N_SEG_DED; i++) begin : g_seg
      if (i < N_GRID) begin : g_keycol
         assign seg_n[i] = lit ? row[i] : (strobe && (digit == DW'(i)));
      end else begin : g_plain
         assign seg_n[i] = lit && row[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grid_o <= '0;
         seg_o  <= '0;
      end else begin
         grid_o <= grid_n;
         seg_o  <= seg_n;
      end
   end

endmodule

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl
   import vfd_pkg::*;
#(
   parameter int N_GRID      = 16,
   parameter int N_SEG_DED   = 24,
   parameter int N_SHARED    = 8,
   parameter int N_RET       = 8,
   parameter int BLANK_CLKS  = 4,
   parameter int STROBE_CLKS = 2,
   parameter int STEP_CLKS   = 2,
   localparam int DW         = $clog2(N_GRID),
   localparam int AW         = DW + 1,
   localparam int SEG_W      = N_SEG_DED + N_SHARED
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic [SEG_W-1:0]        wr_data,
   input  logic [N_RET-1:0]        key_ret,
   output logic [N_GRID-1:0]       grid_o,
   output logic [N_SEG_DED-1:0]    seg_o,
   output logic                    frame_done,
   output logic [N_GRID*N_RET-1:0] key_map
);

   logic [DW-1:0]    digit;
   vfd_phase_e       phase;
   logic             frame_end;
   logic             key_smp;
   logic [SEG_W-1:0] row;
   logic [DW-1:0]    ndig_m1;
   logic [DIM_W-1:0] dim;

   vfd_timing #(
      .N_GRID(N_GRID), .BLANK_CLKS(BLANK_CLKS),
      .STROBE_CLKS(STROBE_CLKS), .STEP_CLKS(STEP_CLKS)
   ) i_timing (
      .clk(clk), .rst_n(rst_n), .ndig_m1(ndig_m1), .dim(dim),
      .digit(digit), .phase(phase), .frame_end(frame_end), .key_smp(key_smp)
   );

   vfd_shadow #(.N_GRID(N_GRID), .SEG_W(SEG_W)) i_shadow (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_end(frame_end), .digit(digit),
      .row_o(row), .ndig_m1_o(ndig_m1), .dim_o(dim)
   );

   vfd_keyscan #(.N_COL(N_GRID), .N_RET(N_RET)) i_keys (
      .clk(clk), .rst_n(rst_n), .key_ret(key_ret), .key_smp(key_smp),
      .frame_end(frame_end), .digit(digit), .ndig_m1(ndig_m1),
      .key_map(key_map)
   );

   vfd_drive #(
      .N_GRID(N_GRID), .N_SEG_DED(N_SEG_DED), .N_SHARED(N_SHARED)
   ) i_drive (
      .clk(clk), .rst_n(rst_n), .phase(phase), .digit(digit),
      .ndig_m1(ndig_m1), .row(row), .grid_o(grid_o), .seg_o(seg_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) frame_done <= 1'b0;
      else        frame_done <= frame_end;
   end

   if ((1 << DW) != N_GRID) begin : g_bad_grid
      $error("vfd_scan_ctrl: N_GRID must be a power of two");
   end
   if (N_SEG_DED < N_GRID) begin : g_bad_cols
      $error("vfd_scan_ctrl: key columns need one dedicated segment line each");
   end
   if (N_SHARED > N_GRID || N_SHARED < 0) begin : g_bad_shared
      $error("vfd_scan_ctrl: N_SHARED out of range");
   end

endmodule

// File: rtl/vfd_scan_ctrl_chk.sv
module vfd_scan_ctrl_chk #(
   parameter int N_GRID    = 16,
   parameter int N_SEG_DED = 24,
   parameter int N_RET     = 8,
   localparam int DW       = $clog2(N_GRID)
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic [N_GRID-1:0]       grid_o,
   input logic [N_SEG_DED-1:0]    seg_o,
   input logic                    frame_done,
   input logic [N_GRID*N_RET-1:0] key_map,
   input logic [DW-1:0]           ndig_m1
);

   // Lines acting as grids for the outputs currently visible (one cycle lag).
   logic [N_GRID-1:0] tmask_n, tmask_q;

   always_comb begin
      for (int j = 0; j < N_GRID; j++) tmask_n[j] = (DW'(j) <= ndig_m1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tmask_q <= '0;
      else        tmask_q <= tmask_n;
   end

   a_r1_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (grid_o == '0 && seg_o == '0 && !frame_done && key_map == '0));

   a_r2_single_grid: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grid_o & tmask_q));

   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   a_r3_blank_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (grid_o == '0 && seg_o == '0));

   a_r5_steady_lit: assert property (@(posedge clk) disable iff (!rst_n)
      ((grid_o & tmask_q) != '0 && (grid_o & tmask_q) == $past(grid_o & tmask_q))
      |-> $stable(seg_o));

   a_r6_shared_needs_grid: assert property (@(posedge clk) disable iff (!rst_n)
      ((grid_o & ~tmask_q) != '0) |-> ((grid_o & tmask_q) != '0));

   a_r10_keys_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(key_map) |-> frame_done);

endmodule

bind vfd_scan_ctrl vfd_scan_ctrl_chk #(
   .N_GRID(N_GRID), .N_SEG_DED(N_SEG_DED), .N_RET(N_RET)
) i_chk (
   .clk(clk), .rst_n(rst_n), .grid_o(grid_o), .seg_o(seg_o),
   .frame_done(frame_done), .key_map(key_map), .ndig_m1(ndig_m1)
);

// File: tb/test_vfd_scan_ctrl.sv
module test_vfd_scan_ctrl;

   localparam int NG = 16, NSD = 24, NSH = 8, NR = 8;
   localparam int BL = 4, SB = 2, ST = 2;
   localparam int SLOT = BL + SB + 8 * ST;
   localparam int SW = NSD + NSH, AW = 5;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           wr_en;
   logic [AW-1:0]  wr_addr;
   logic [SW-1:0]  wr_data;
   logic [NR-1:0]  key_ret;
   logic [NG-1:0]  grid_o;
   logic [NSD-1:0] seg_o;
   logic           frame_done;
   logic [NG*NR-1:0] key_map;

   always #5 clk = ~clk;

   vfd_scan_ctrl i_vfd_scan_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .key_ret(key_ret), .grid_o(grid_o), .seg_o(seg_o),
      .frame_done(frame_done), .key_map(key_map)
   );

   // Key matrix model: a pressed key joins its strobe column to its return row.
   logic [NR-1:0] kmat [NG];
   always_comb begin
      key_ret = '0;
      for (int c = 0; c < NG; c++) if (seg_o[c]) key_ret = key_ret | kmat[c];
   end

   int nchk = 0, nerr = 0, ci = 0;
   int m_ndig = 1, m_dim = 0, p_ndig = 1, p_dim = 0;
   logic [SW-1:0] m_ram [NG];
   logic [SW-1:0] p_ram [NG];
   logic [NR-1:0] k_prev [NG];
   logic [NR-1:0] k_map [NG];
   string lit_tag = "R5", next_tag = "R5";

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int exp_out(input int i, output logic [NG-1:0] g,
                                  output logic [NSD-1:0] s);
      int d, c, k;
      d = i / SLOT; c = i % SLOT; g = '0; s = '0;
      if (c < BL) return 0;
      if (c < BL + SB) begin s[d] = 1'b1; return 1; end
      k = c - BL - SB;
      if (k < (m_dim + 1) * ST) begin
         g[d] = 1'b1;
         s = m_ram[d][NSD-1:0];
         for (int j = NG - NSH; j < NG; j++)
            if (m_ndig <= j) g[j] = m_ram[d][NSD + j - (NG - NSH)];
         return 2;
      end
      return 3;
   endfunction

   task automatic frame_end_model();
      logic [NG*NR-1:0] ek;
      bit held = 0;
      for (int c = 0; c < NG; c++) begin
         if (c < m_ndig) begin
            if (kmat[c] == k_prev[c]) k_map[c] = kmat[c];
            else held = 1;
            k_prev[c] = kmat[c];
         end else begin
            if (k_map[c] != '0) held = 1;
            k_map[c] = '0; k_prev[c] = '0;
         end
         ek[c*NR +: NR] = k_map[c];
      end
      chk(key_map == ek, held ? "R10" : "R9", "key_map", key_map, ek);
      for (int r = 0; r < NG; r++) m_ram[r] = p_ram[r];
      m_ndig = p_ndig; m_dim = p_dim;
      lit_tag = next_tag; next_tag = "R5";
   endtask

   task automatic cycle();
      logic [NG-1:0] g, sm;
      logic [NSD-1:0] s;
      int ph;
      string tag;
      @(negedge clk);
      ph = exp_out(ci, g, s);
      sm = '0;
      for (int j = NG - NSH; j < NG; j++) if (m_ndig <= j) sm[j] = 1'b1;
      tag = (ph == 0) ? "R3" : (ph == 1) ? "R4" : lit_tag;
      if (sm != '0 && ph == 2)
         chk((grid_o & sm) == (g & sm), "R6", "shared lines", grid_o, g);
      chk((grid_o & ~sm) == (g & ~sm), tag, "grid", grid_o, g);
      chk(seg_o == s, tag, "seg", seg_o, s);
      chk(frame_done == (ci == m_ndig * SLOT - 1), "R2", "frame_done",
          frame_done, (ci == m_ndig * SLOT - 1));
      if (ci == m_ndig * SLOT - 1) begin
         frame_end_model();
         ci = 0;
      end else ci++;
   endtask

   task automatic wr(input int addr, input logic [SW-1:0] data);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
      if (addr < NG) begin p_ram[addr] = data; lit_tag = "R8"; end
      else if (addr == NG) begin
         p_ndig = int'(data[3:0]) + 1; p_dim = int'(data[6:4]); lit_tag = "R8";
      end else next_tag = "R7";
      cycle();
      wr_en = 1'b0;
   endtask

   function automatic logic [SW-1:0] ctrl(input int nd, input int dm);
      return SW'(((dm & 7) << 4) | ((nd - 1) & 15));
   endfunction

   initial begin
      #1_500_000;
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      int seed, nd, dm;
      bit synced;
      seed = $urandom(32'd2441);
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      for (int c = 0; c < NG; c++) begin
         kmat[c] = '0; k_prev[c] = '0; k_map[c] = '0; m_ram[c] = '0; p_ram[c] = '0;
      end
      repeat (3) begin
         @(negedge clk);
         chk(grid_o == '0 && seg_o == '0, "R1", "lines in reset", {grid_o, seg_o}, 0);
         chk(!frame_done && key_map == '0, "R1", "done/keys in reset", key_map, 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(grid_o == '0 && seg_o == '0 && !frame_done, "R1", "first cycle",
          {grid_o, seg_o}, 0);
      synced = 0;
      for (int n = 0; n < 200 && !synced; n++) begin
         @(negedge clk);
         if (frame_done) synced = 1;
      end
      chk(synced, "R2", "first frame_done seen", synced, 1);
      chk(key_map == '0, "R1", "keys after first frame", key_map, 0);
      ci = 0;

      for (int f = 0; f < 60; f++) begin
         // Key pattern for this frame.
         if (f == 1) for (int c = 0; c < NG; c++) kmat[c] = NR'(c * 37 + 5);
         else if (f >= 7 && ($urandom % 3) == 0) begin
            for (int c = 0; c < NG; c++)
               if (($urandom % 2) == 0) kmat[c] = NR'($urandom);
         end
         cycle(); cycle();
         if (f == 0) begin
            for (int r = 0; r < NG; r++) wr(r, SW'($urandom));
            wr(NG, ctrl(16, 7));
         end else if (f == 3) begin
            wr(NG, ctrl(1, 0));
            wr(17, SW'($urandom));
            wr(31, ctrl(16, 5));
         end else if (f == 4) wr(NG, ctrl(8, 2));
         else if (f == 5) begin wr(8, SW'($urandom)); wr(NG, ctrl(9, 3)); end
         else if (f == 6) wr(NG, ctrl(16, 0));
         else if (f >= 7) begin
            int nw;
            nw = $urandom % 4;
            for (int w = 0; w < nw; w++) wr($urandom % NG, SW'($urandom));
            if (($urandom % 3) == 0) begin
               case ($urandom % 5)
                  0: nd = 1; 1: nd = 8; 2: nd = 9; 3: nd = 16;
                  default: nd = 1 + ($urandom % 16);
               endcase
               dm = $urandom % 8;
               wr(NG, ctrl(nd, dm));
            end
            if (($urandom % 5) == 0) wr(17 + ($urandom % 15), SW'($urandom));
         end
         do cycle(); while (ci != 0);
      end

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule